// File: doc/BRIEF.md
# Reversible Pulse Counter with Chainable Overflow Outputs

This block is a small up/down counter in which the direction comes from which of two count inputs receives a pulse, not from a mode pin. An idle count input rests high. A count step is taken when one input rises while the other stays high. Both count inputs may be asynchronous to the block. They pass through synchronizers into a free-running system clock and are edge-detected there, so a pulse must last a few system clocks to be seen. An active-high clear and an active-low parallel load override counting. A parameter selects binary terminal values or decade terminal values (0 to 9).

Two active-low chaining outputs make wide counters without glue logic. The overflow output follows the up input low while the count sits at its top value. The underflow output follows the down input low while the count sits at zero. Wiring overflow to the next stage's up input and underflow to its down input gives that stage its step at the moment the lower stage wraps.

Top module: `updn_pulse_counter`

## Requirements
- R1: A rising edge on `cnt_up_i` while `cnt_dn_i` is high adds one to `count_o`. The new value appears on the third system clock edge after the rise.
- R2: A rising edge on `cnt_dn_i` while `cnt_up_i` is high subtracts one from `count_o`, with the same latency as R1.
- R3: `clr_i` high sets `count_o` to zero on the next clock edge. It wins over a low `load_n_i` and over any count step.
- R4: While `load_n_i` is low and `clr_i` is low, `count_o` takes `data_i` on each clock edge, and count edges are ignored.
- R5: `ovf_n_o` is low exactly when the synchronized up input is low and the count equals its top value. It lags both by one clock, and it is high otherwise.
- R6: `unf_n_o` is low exactly when the synchronized down input is low and the count is zero. It lags both by one clock, and it is high otherwise.
- R7: Counting up from the top value gives zero. Counting down from zero gives the top value. The binary top value is 2^WIDTH-1.
- R8: A rising edge on one count input while the other input is low causes no step. Rising edges on both inputs in the same sampled cycle cause no step.
- R9: With DECADE=1 the top value is 9. Up from 9 gives 0, down from 0 gives 9, and the overflow output goes low at 9.
- R10: Two stages chained through `ovf_n_o`/`unf_n_o` into the next stage's up/down inputs act as one counter of twice the width, both up and down.
- R11: After reset, `count_o` is zero and both chaining outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_up_i | input | 1 | Up count pulse input, idles high |
| cnt_dn_i | input | 1 | Down count pulse input, idles high |
| clr_i | input | 1 | Active-high clear |
| load_n_i | input | 1 | Active-low parallel load |
| data_i | input | WIDTH | Parallel load value |
| count_o | output | WIDTH | Current count |
| ovf_n_o | output | 1 | Active-low overflow pulse for chaining |
| unf_n_o | output | 1 | Active-low underflow pulse for chaining |

## Verification
Clear and load act on the first clock edge after they are driven. A count edge lands on the third edge: two synchronizer stages, then the count register. A chaining output settles one edge after its synchronized input or the count changes, and a chained upper stage moves about three edges after that. The driver pushes an expected value only after the relevant latency has passed, and a short settle time is added for chained stages. It pushes at a falling clock edge. The monitor compares a little later in the same low phase, and none of these outputs can move there. One check samples the count on the second edge after a count edge, and again on the third, to pin the exact latency.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  function automatic int top_value(input int width, input bit decade);
    return decade ? 9 : ((1 << width) - 1);
  endfunction
endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-2:0], din};
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/updn_edge.sv
module updn_edge
  import updn_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lvl,      // [0] up, [1] down, synchronized
  output step_e      step
);
  logic [1:0] prev_q;
  logic [1:0] rise;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 2'b11;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  always_comb begin
    step = STEP_NONE;
    if (rise == 2'b01 && lvl[1])      step = STEP_UP;
    else if (rise == 2'b10 && lvl[0]) step = STEP_DN;
  end

  AST_NO_STEP_OTHER_LOW: assert property (@(posedge clk) disable iff (rst)
    (lvl != 2'b11) |-> (step == STEP_NONE)); // R8
endmodule

// File: rtl/updn_core.sv
module updn_core
  import updn_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int TOP   = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data,
  input  step_e            step,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] TOPV = WIDTH'(TOP);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (!load_n) begin
      count <= data;
    end else begin
      case (step)
        STEP_UP: count <= (count >= TOPV) ? '0 : count + 1'b1;
        STEP_DN: count <= (count == '0) ? TOPV : count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0)); // R3
  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load_n) |=> (count == $past(data))); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n && step == STEP_NONE) |=> $stable(count)); // R8
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n && step == STEP_UP && count == TOPV) |=> (count == '0)); // R7
  AST_DN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clr && load_n && step == STEP_DN && count == '0) |=> (count == TOPV)); // R7
endmodule

// File: rtl/updn_term.sv
module updn_term #(
  parameter int WIDTH = 4,
  parameter int TOP   = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  input  logic [WIDTH-1:0] count,
  output logic             ovf_n,
  output logic             unf_n
);
  localparam logic [WIDTH-1:0] TOPV = WIDTH'(TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_n <= 1'b1;
      unf_n <= 1'b1;
    end else begin
      ovf_n <= ~(~up_lvl && (count == TOPV));
      unf_n <= ~(~dn_lvl && (count == '0));
    end
  end

  AST_OVF_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    (count != TOPV) |=> ovf_n); // R5
  AST_UNF_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |=> unf_n); // R6
  AST_OVF_FOLLOWS_UP: assert property (@(posedge clk) disable iff (rst)
    up_lvl |=> ovf_n); // R5
endmodule

// File: rtl/updn_pulse_counter.sv
module updn_pulse_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit DECADE      = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_up_i,
  input  logic             cnt_dn_i,
  input  logic             clr_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             ovf_n_o,
  output logic             unf_n_o
);
  localparam int TOP = top_value(WIDTH, DECADE);

  logic [1:0] raw;
  logic [1:0] lvl;
  step_e      step;

  assign raw = {cnt_dn_i, cnt_up_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    updn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw[g]),
      .dout(lvl[g])
    );
  end

  updn_edge u_edge (
    .clk (clk),
    .rst (rst),
    .lvl (lvl),
    .step(step)
  );

  updn_core #(.WIDTH(WIDTH), .TOP(TOP)) u_core (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_i),
    .load_n(load_n_i),
    .data  (data_i),
    .step  (step),
    .count (count_o)
  );

  updn_term #(.WIDTH(WIDTH), .TOP(TOP)) u_term (
    .clk   (clk),
    .rst   (rst),
    .up_lvl(lvl[0]),
    .dn_lvl(lvl[1]),
    .count (count_o),
    .ovf_n (ovf_n_o),
    .unf_n (unf_n_o)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (count_o == '0 && ovf_n_o && unf_n_o)); // R11
endmodule

// File: tb/sim_updn_pulse_counter.sv
module sim_updn_pulse_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up = 1'b1, dn = 1'b1, clr = 1'b0, load_n = 1'b1, dload_n = 1'b1;
  logic [3:0] d_lo = '0, d_hi = '0, d_dec = '0;
  logic [3:0] c0, c1, c2;
  logic ov0, un0, ov1, un1, ov2, un2;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  updn_pulse_counter #(.WIDTH(4), .DECADE(1'b0)) u0 (
    .clk(clk), .rst(rst), .cnt_up_i(up), .cnt_dn_i(dn), .clr_i(clr),
    .load_n_i(load_n), .data_i(d_lo), .count_o(c0), .ovf_n_o(ov0), .unf_n_o(un0));
  updn_pulse_counter #(.WIDTH(4), .DECADE(1'b0)) u1 (
    .clk(clk), .rst(rst), .cnt_up_i(ov0), .cnt_dn_i(un0), .clr_i(clr),
    .load_n_i(load_n), .data_i(d_hi), .count_o(c1), .ovf_n_o(ov1), .unf_n_o(un1));
  updn_pulse_counter #(.WIDTH(4), .DECADE(1'b1)) u2 (
    .clk(clk), .rst(rst), .cnt_up_i(up), .cnt_dn_i(dn), .clr_i(clr),
    .load_n_i(dload_n), .data_i(d_dec), .count_o(c2), .ovf_n_o(ov2), .unf_n_o(un2));

  typedef struct { string req; int sel; int exp; } item_t;
  item_t sb[$];

  function automatic int pick(int sel);
    case (sel)
      0: return int'(c0);
      1: return int'(c1);
      2: return int'(c2);
      3: return int'(ov0);
      4: return int'(un0);
      5: return int'(ov2);
      default: return -1;
    endcase
  endfunction

  // monitor: compares queued expectations in the low clock phase
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        tests++;
        if (pick(it.sel) != it.exp) begin
          fails++;
          $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, pick(it.sel), it.exp);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_v(string req, int sel, int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic pulse_up();
    up = 1'b0; step(4); up = 1'b1; step(8);
  endtask

  task automatic pulse_dn();
    dn = 1'b0; step(4); dn = 1'b1; step(8);
  endtask

  task automatic load_pair(logic [3:0] lo, logic [3:0] hi);
    d_lo = lo; d_hi = hi; load_n = 1'b0; step(1); load_n = 1'b1; step(1);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    expect_v("R11 count", 0, 0); expect_v("R11 ovf", 3, 1); expect_v("R11 unf", 4, 1);
    expect_v("R11 upper", 1, 0);
    step(1);

    // R1 exact latency
    up = 1'b0; step(4); up = 1'b1; step(2);
    expect_v("R1 not yet", 0, 0);
    step(1);
    expect_v("R1 third edge", 0, 1);
    step(5);
    pulse_up(); pulse_up(); pulse_up();
    expect_v("R1 four ups", 0, 4);
    pulse_dn();
    expect_v("R2 down", 0, 3); expect_v("R2 decade down", 2, 3);

    // R4 load, counting ignored while low
    d_lo = 4'd10; d_hi = 4'd0; load_n = 1'b0; step(1);
    expect_v("R4 load", 0, 10);
    pulse_up();
    expect_v("R4 ignore count", 0, 10);
    load_n = 1'b1; step(1);

    // R3 clear beats load
    d_lo = 4'd7; load_n = 1'b0; clr = 1'b1; step(1);
    expect_v("R3 clear", 0, 0); expect_v("R3 clear dec", 2, 0); expect_v("R3 clear upper", 1, 0);
    clr = 1'b0; load_n = 1'b1; step(1);

    // R6 underflow, R7 wrap down, R9 decade, R10 chain borrow
    dn = 1'b0; step(4);
    expect_v("R6 unf low", 4, 0);
    dn = 1'b1; step(8);
    expect_v("R7 wrap down", 0, 15); expect_v("R10 borrow chain", 1, 15);
    expect_v("R9 decade down wrap", 2, 9); expect_v("R6 unf release", 4, 1);

    // R5 overflow, R7 wrap up, R9, R10 carry
    up = 1'b0; step(4);
    expect_v("R5 ovf low", 3, 0); expect_v("R9 decade ovf", 5, 0);
    up = 1'b1; step(8);
    expect_v("R7 wrap up", 0, 0); expect_v("R10 carry chain", 1, 0);
    expect_v("R9 decade up wrap", 2, 0); expect_v("R5 ovf release", 3, 1);

    // R5 no overflow away from top
    up = 1'b0; step(4);
    expect_v("R5 ovf stays high", 3, 1);
    up = 1'b1; step(8);
    expect_v("R1 up from zero", 0, 1);

    // R8 up rises while down low
    dn = 1'b0; step(4); up = 1'b0; step(4); up = 1'b1; step(4);
    expect_v("R8 other low", 0, 1);
    dn = 1'b1; step(8);
    expect_v("R2 down after", 0, 0); expect_v("R8 chain untouched", 1, 0);

    // R8 simultaneous edges
    load_pair(4'd5, 4'd2);
    up = 1'b0; dn = 1'b0; step(4);
    up = 1'b1; dn = 1'b1; step(8);
    expect_v("R8 both rise", 0, 5); expect_v("R8 both rise upper", 1, 2);

    // R10 chain down then up
    load_pair(4'd0, 4'd2);
    pulse_dn();
    expect_v("R10 down lo", 0, 15); expect_v("R10 down hi", 1, 1);
    pulse_up();
    expect_v("R10 up lo", 0, 0); expect_v("R10 up hi", 1, 2);

    // R9 decade from loaded 8
    d_dec = 4'd8; dload_n = 1'b0; step(1); dload_n = 1'b1; step(1);
    pulse_up();
    expect_v("R9 decade to 9", 2, 9);
    pulse_up();
    expect_v("R9 decade 9 to 0", 2, 0);

    step(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule